// File: doc/BRIEF.md
# Light Sensor Measurement Control Core

This block is the digital sequencing core of a combined ambient and infrared light sensor. Software reaches it through a small byte-wide register port: address, write data, write strobe and a registered read-data bus. A three-bit mode field picks the channel (ambient or infrared) and the sequencing (one conversion or back-to-back conversions). Each conversion counts the pulses seen on the selected channel input over a fixed window. A two-bit resolution code sets both the window length and the width of the result.

At the end of each window the count is stored into a pair of read-only data bytes. If the result is at or below a 16-bit lower threshold, a sticky interrupt flag is set, and the interrupt pin follows that flag. One-shot modes clear the mode field by themselves when their conversion completes. Any write to the mode or configuration register abandons the conversion in flight and starts a fresh window under the new settings. A two-bit range field is stored and read back but has no effect here.

Top module: `light_meas_core`

## Requirements
- R1: After reset, addresses 0x00 to 0x05 all read 0x00 and `irq` is low.
- R2: Register 0x00 reads as {mode[2:0], 2'b00, flag, 2'b00}. Register 0x01 keeps write bits 3:0 (resolution in 3:2, range in 1:0) and reads zero in bits 7:4. Registers 0x04 and 0x05 hold the low and high bytes of the threshold and read back as written. Writing 1 to bit 2 of 0x00 never sets the flag.
- R3: Mode 001 runs one ambient conversion that counts `amb_pulse` samples and ignores `ir_pulse`. Mode 010 is the same for `ir_pulse` and ignores `amb_pulse`. When the one conversion completes, the mode field returns to 000.
- R4: Rsolution code 11 gives a 16-cycle window, 10 gives 256, 01 gives 4,096 and 00 gives 65,536. A window counts the samples taken on its clock edges, and the first sampling edge is the second rising edge after the write that starts it.
- R5: The pulse count saturates at 2^n-1 for an n-bit result (n = 4, 8, 12 or 16 for codes 11, 10, 01, 00) instead of wrapping.
- R6: The result sits right-aligned: bits 7:0 read at 0x02 and bits 15:8 at 0x03, with unused upper bits zero.
- R7: The data bytes change only at the edge that completes a conversion; reads during a window return the previous result.
- R8: A completed result less than or equal to the threshold sets the flag. A result greater than the threshold leaves it unchanged. The comparison uses all 16 threshold bits.
- R9: The flag stays set until a write to 0x00 with bit 2 equal to 0, and `irq` equals the flag.
- R10: Mode codes 011, 100 and 111 are stored and read back but start no conversion, like 000.
- R11: A write to 0x00 or 0x01 during a window aborts it without updating the data bytes and starts a new window.
- R12: Modes 101 and 110 repeat conversions back to back. If a completion and a flag-clearing write to 0x00 fall on the same edge, the result is stored and the flag ends up set.
- R13: Writes to 0x02 and 0x03 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle high |
| rd_data | output | 8 | Read data for the previous cycle's address |
| amb_pulse | input | 1 | Ambient channel pulse input, sampled each cycle |
| ir_pulse | input | 1 | Infrared channel pulse input, sampled each cycle |
| irq | output | 1 | Interrupt pin, equal to the sticky flag |

## Verification
The completion of a continuous conversion and a software write to the mode register can land on the same clock edge. That write both clears the flag and aborts the window. The bench starts continuous ambient conversions at 4-bit resolution with the threshold at 0xFFFF, counts edges from the starting write, and issues a flag-clearing write exactly on the seventeenth edge, where the first window closes. There `irq` must read high, because the set wins. The same write moved one edge earlier, inside the following window, must leave `irq` low, because the abort prevents that completion.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  localparam logic [2:0] MODE_OFF      = 3'b000;
  localparam logic [2:0] MODE_AMB_ONCE = 3'b001;
  localparam logic [2:0] MODE_IR_ONCE  = 3'b010;
  localparam logic [2:0] MODE_AMB_RUN  = 3'b101;
  localparam logic [2:0] MODE_IR_RUN   = 3'b110;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_CFG  = 1;
  localparam int unsigned ADR_DLO  = 2;
  localparam int unsigned ADR_DHI  = 3;
  localparam int unsigned ADR_TLO  = 4;
  localparam int unsigned ADR_THI  = 5;

  // a mode that runs conversions
  function automatic logic mode_active(input logic [2:0] m);
    return (m == MODE_AMB_ONCE) || (m == MODE_IR_ONCE) ||
           (m == MODE_AMB_RUN)  || (m == MODE_IR_RUN);
  endfunction

  // one-shot modes have the top bit clear
  function automatic logic mode_single(input logic [2:0] m);
    return !m[2];
  endfunction

  // infrared modes have bit 1 set
  function automatic logic mode_ir(input logic [2:0] m);
    return m[1];
  endfunction

  // result width for a resolution code
  function automatic int unsigned res_bits(input logic [1:0] r,
                                           input int unsigned full,
                                           input int unsigned step);
    return full - step * int'(r);
  endfunction

endpackage

// File: rtl/lmc_regs.sv
module lmc_regs
  import lmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              done,
  input  logic              single_done,
  input  logic [CNT_W-1:0]  result,
  output logic [2:0]        mode_q,
  output logic [RES_W-1:0]  res_q,
  output logic [CNT_W-1:0]  thr_q,
  output logic [CNT_W-1:0]  data_q,
  output logic              flag_q,
  output logic              cfg_wr
);

  localparam int unsigned RNG_W = 2;

  logic [RNG_W-1:0] rng_q;
  logic             wr_ctrl;
  logic             wr_cfg;

  assign wr_ctrl = wr_en && (reg_addr == ADDR_W'(ADR_CTRL));
  assign wr_cfg  = wr_en && (reg_addr == ADDR_W'(ADR_CFG));
  assign cfg_wr  = wr_ctrl || wr_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_OFF;
      res_q   <= '0;
      rng_q   <= '0;
      thr_q   <= '0;
      data_q  <= '0;
      flag_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      // one-shot completion clears the mode unless software rewrites it
      if (single_done && !wr_ctrl)
        mode_q <= MODE_OFF;
      if (wr_ctrl) begin
        mode_q <= wr_data[7:5];
        if (!wr_data[2])
          flag_q <= 1'b0;
      end
      if (wr_cfg) begin
        res_q <= wr_data[RNG_W+RES_W-1:RNG_W];
        rng_q <= wr_data[RNG_W-1:0];
      end
      if (wr_en && reg_addr == ADDR_W'(ADR_TLO))
        thr_q[DATA_W-1:0] <= wr_data;
      if (wr_en && reg_addr == ADDR_W'(ADR_THI))
        thr_q[CNT_W-1:DATA_W] <= wr_data;
      // completion commits after the write so a set beats a clear
      if (done) begin
        data_q <= result;
        if (result <= thr_q)
          flag_q <= 1'b1;
      end
      case (int'(reg_addr))
        ADR_CTRL: rd_data <= {mode_q, 2'b00, flag_q, 2'b00};
        ADR_CFG:  rd_data <= DATA_W'({res_q, rng_q});
        ADR_DLO:  rd_data <= data_q[DATA_W-1:0];
        ADR_DHI:  rd_data <= data_q[CNT_W-1:DATA_W];
        ADR_TLO:  rd_data <= thr_q[DATA_W-1:0];
        ADR_THI:  rd_data <= thr_q[CNT_W-1:DATA_W];
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lmc_conv.sv
module lmc_conv
  import lmc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RES_W    = 2,
  parameter int unsigned RES_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [RES_W-1:0] res,
  input  logic             cfg_wr,
  input  logic             amb_pulse,
  input  logic             ir_pulse,
  output logic             run,
  output logic             done,
  output logic [CNT_W-1:0] acc,
  output logic [CNT_W-1:0] result
);

  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] acc_nxt;
  logic             sample;
  int unsigned      nbits;

  always_comb begin
    nbits   = res_bits(res, CNT_W, RES_STEP);
    last    = ~({CNT_W{1'b1}} << nbits);
    sample  = mode_ir(mode) ? ir_pulse : amb_pulse;
    acc_nxt = (sample && (acc != last)) ? acc + 1'b1 : acc;
  end

  assign done   = run && (win == last);
  assign result = acc_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      win <= '0;
      acc <= '0;
    end else if (cfg_wr) begin
      run <= 1'b0;
      win <= '0;
      acc <= '0;
    end else if (!run) begin
      run <= mode_active(mode);
      win <= '0;
      acc <= '0;
    end else if (done) begin
      run <= !mode_single(mode);
      win <= '0;
      acc <= '0;
    end else begin
      win <= win + 1'b1;
      acc <= acc_nxt;
    end
  end

endmodule

// File: rtl/light_meas_core.sv
module light_meas_core
  import lmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RES_W    = 2,
  parameter int unsigned RES_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              amb_pulse,
  input  logic              ir_pulse,
  output logic              irq
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [2:0]       mode_q;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] data_q;
  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] result;
  logic             flag_q;
  logic             cfg_wr;
  logic             run;
  logic             done;
  logic             single_done;

  assign single_done = done && mode_single(mode_q);
  assign irq         = flag_q;

  lmc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RES_W(RES_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .single_done(single_done), .result(result), .mode_q(mode_q),
    .res_q(res_q), .thr_q(thr_q), .data_q(data_q), .flag_q(flag_q),
    .cfg_wr(cfg_wr)
  );

  lmc_conv #(
    .CNT_W(CNT_W), .RES_W(RES_W), .RES_STEP(RES_STEP)
  ) u_conv (
    .clk(clk), .rst(rst), .mode(mode_q), .res(res_q), .cfg_wr(cfg_wr),
    .amb_pulse(amb_pulse), .ir_pulse(ir_pulse), .run(run), .done(done),
    .acc(acc), .result(result)
  );

endmodule

// File: rtl/lmc_chk.sv
module lmc_chk
  import lmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RES_W    = 2,
  parameter int unsigned RES_STEP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_bit2,
  input logic              irq,
  input logic [2:0]        mode,
  input logic [RES_W-1:0]  res,
  input logic              run,
  input logic              done,
  input logic [CNT_W-1:0]  acc,
  input logic [CNT_W-1:0]  result,
  input logic [CNT_W-1:0]  thr,
  input logic [CNT_W-1:0]  data_q
);

  logic [CNT_W-1:0] cap;
  assign cap = ~({CNT_W{1'b1}} << res_bits(res, CNT_W, RES_STEP));

  // R5
  acc_sat_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (acc <= cap));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(data_q));

  // R8
  thr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (result <= thr)) |=> irq);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_en && reg_addr == ADDR_W'(ADR_CTRL) && !wr_bit2)) |=> irq);

  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_active(mode) |=> !run);

endmodule

bind light_meas_core lmc_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RES_W(RES_W), .RES_STEP(RES_STEP)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_bit2(wr_data[2]), .irq(irq), .mode(mode_q), .res(res_q), .run(run),
  .done(done), .acc(acc), .result(result), .thr(thr_q), .data_q(data_q)
);

// File: tb/light_meas_core_tb.sv
`timescale 1ns/1ps
module light_meas_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data;
  logic       amb_pulse = 1'b0;
  logic       ir_pulse = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  light_meas_core u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_data(rd_data), .amb_pulse(amb_pulse),
    .ir_pulse(ir_pulse), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start a conversion, drive the selected pulse from sampling edge 1
  task automatic pulse_run(input logic [7:0] modew, input bit use_ir,
                           input int skip, input int cnt);
    wr(3'd0, modew);
    idle(1 + skip);
    if (use_ir) ir_pulse = 1'b1; else amb_pulse = 1'b1;
    idle(cnt);
    if (use_ir) ir_pulse = 1'b0; else amb_pulse = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) rd_chk("R1 reset value", 3'(a), 0);
    check("R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_regs;
    wr(3'd1, 8'hFF);
    rd_chk("R2 cfg upper bits zero", 3'd1, 8'h0F);
    wr(3'd0, 8'h1F);
    rd_chk("R2 ctrl layout, flag not set by write", 3'd0, 8'h00);
    wr(3'd4, 8'h12);
    wr(3'd5, 8'h34);
    rd_chk("R2 threshold low", 3'd4, 8'h12);
    rd_chk("R2 threshold high", 3'd5, 8'h34);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_readonly;
    wr(3'd2, 8'h55);
    wr(3'd3, 8'hAA);
    rd_chk("R13 data low not writable", 3'd2, 0);
    rd_chk("R13 data high not writable", 3'd3, 0);
  endtask

  task automatic t_amb_once;
    wr(3'd1, 8'h0C);
    ir_pulse = 1'b1;
    pulse_run(8'h20, 1'b0, 0, 5);
    ir_pulse = 1'b0;
    idle(30);
    rd_chk("R3 ambient count", 3'd2, 5);
    rd_chk("R6 high byte zero", 3'd3, 0);
    rd_chk("R3 mode back to off", 3'd0, 0);
    check("R8 no flag above threshold", int'(irq), 0);
  endtask

  task automatic t_window;
    pulse_run(8'h20, 1'b0, 11, 20);
    idle(20);
    rd_chk("R4 16-cycle window edge", 3'd2, 5);
    wr(3'd1, 8'h08);
    pulse_run(8'h20, 1'b0, 249, 20);
    idle(20);
    rd_chk("R4 256-cycle window edge", 3'd2, 7);
  endtask

  task automatic t_ir;
    amb_pulse = 1'b1;
    pulse_run(8'h40, 1'b1, 0, 200);
    amb_pulse = 1'b0;
    idle(70);
    rd_chk("R3 infrared count ignores ambient", 3'd2, 8'hC8);
    rd_chk("R3 infrared high byte", 3'd3, 0);
  endtask

  task automatic t_sat;
    pulse_run(8'h40, 1'b1, 0, 300);
    idle(10);
    rd_chk("R5 8-bit saturation", 3'd2, 8'hFF);
    rd_chk("R5 8-bit saturation high", 3'd3, 0);
    wr(3'd1, 8'h0C);
    pulse_run(8'h20, 1'b0, 0, 40);
    idle(5);
    rd_chk("R5 4-bit saturation", 3'd2, 8'h0F);
  endtask

  task automatic t_wide;
    wr(3'd1, 8'h04);
    pulse_run(8'h20, 1'b0, 0, 3000);
    rd_chk("R7 old low byte mid window", 3'd2, 8'h0F);
    rd_chk("R7 old high byte mid window", 3'd3, 0);
    idle(1200);
    rd_chk("R6 12-bit low byte", 3'd2, 8'hB8);
    rd_chk("R6 12-bit high byte", 3'd3, 8'h0B);
  endtask

  task automatic t_thresh;
    wr(3'd4, 8'd10); wr(3'd5, 8'd0);
    wr(3'd1, 8'h0C);
    pulse_run(8'h20, 1'b0, 0, 10);
    idle(20);
    check("R8 equal to threshold sets irq", int'(irq), 1);
    rd_chk("R2 flag bit in ctrl", 3'd0, 8'h04);
    idle(20);
    check("R9 flag sticky", int'(irq), 1);
    wr(3'd0, 8'h04);
    check("R9 writing one keeps flag", int'(irq), 1);
    wr(3'd0, 8'h00);
    check("R9 writing zero clears flag", int'(irq), 0);
    pulse_run(8'h20, 1'b0, 0, 11);
    idle(20);
    check("R8 above threshold no irq", int'(irq), 0);
    rd_chk("R8 result stored", 3'd2, 11);
    wr(3'd5, 8'h01);
    wr(3'd1, 8'h08);
    pulse_run(8'h20, 1'b0, 0, 200);
    idle(70);
    check("R8 high threshold byte used", int'(irq), 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] codes [3] = '{8'h60, 8'h80, 8'hE0};
    for (int i = 0; i < 3; i++) begin
      amb_pulse = 1'b1;
      wr(3'd0, codes[i]);
      idle(300);
      amb_pulse = 1'b0;
      rd_chk("R10 reserved code starts nothing", 3'd2, 8'hC8);
      rd_chk("R10 reserved code stored", 3'd0, int'(codes[i]));
      check("R10 no irq", int'(irq), 0);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_abort;
    pulse_run(8'h20, 1'b0, 0, 100);
    wr(3'd1, 8'h08);
    idle(300);
    rd_chk("R11 restarted window result", 3'd2, 0);
    rd_chk("R11 restarted high byte", 3'd3, 0);
    check("R11 restarted result flags", int'(irq), 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_collide;
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h0C);
    amb_pulse = 1'b1;
    wr(3'd0, 8'hA0);
    idle(16);
    wr(3'd0, 8'hA0);
    check("R12 set beats clear on completion edge", int'(irq), 1);
    idle(15);
    wr(3'd0, 8'hA0);
    check("R12 clear inside window", int'(irq), 0);
    rd_chk("R12 continuous mode kept", 3'd0, 8'hA0);
    idle(40);
    check("R12 continuous repeats", int'(irq), 1);
    rd_chk("R12 continuous result", 3'd2, 8'h0F);
    wr(3'd0, 8'h00);
    amb_pulse = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regs;
    t_readonly;
    t_amb_once;
    t_window;
    t_ir;
    t_sat;
    t_wide;
    t_thresh;
    t_reserved;
    t_abort;
    t_collide;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule